// File: doc/BRIEF.md
# Hash Operation Control Sequencer

This block is the control front end of a block-based hash and HMAC engine. Software programs it through a small 32-bit register port. A mode word selects the digest algorithm and four self-clearing step flags. A byte-count word holds the running digest length, and writing the length word launches a run. From then on the sequencer steps an external compression core through a series of operations. Each operation is started with a one-cycle pulse and finishes when the core answers with a done pulse. After each operation the sequencer updates the byte count, the remaining length and the mode flags.

A full HMAC run proceeds in stages: key processing, inner data blocks, a closing pad block and the outer hash. Each step flag clears itself once its stage has run, so the mode word always shows which work is still pending. A context-switch request taken at a block boundary parks the run. The remaining length and the byte count can then be read back, and writing the length again resumes the run.

Top module: `hash_seq_ctrl`

## Requirements
- R1: After reset the mode, count, length and status words read 0, `busy` is low and no core operation is started.
- R2: The mode word keeps only these bits: [2:1] is the algorithm (0 MD5-128, 1 SHA-1-160, 2 SHA-224, 3 SHA-256), 3 is use-constants, 4 is close, 5 is key processing and 7 is outer hash. All other bits read 0. `core_algo` always shows bits [2:1].
- R3: A write to the count word (address 1) stores the value with bits [5:0] forced to zero.
- R4: A write to the length word (address 2) while idle starts a run. A length of 0 with no step flags set starts no core operation and sets the done status bit (bit 3) at once.
- R5: Each 64-byte data block is one operation: `core_start` is high for exactly one cycle, and the count grows by 64 and the length shrinks by 64 only after `core_done`. At the end, the count reads the initial count plus the bytes processed.
- R6: With use-constants set, the count is forced to 0 at launch. `core_const` is high on the first operation only, and the flag then reads 0.
- R7: With key processing set, the count is forced to 64 at launch and a key operation (op code 0) is issued first. The flag clears after it, and data blocks follow.
- R8: With close set, a final operation (op code 2) follows the data blocks. `core_tail` carries the leftover length below 64. The leftover is added to the count, the length becomes 0 and the close flag clears.
- R9: With close clear, a length that is not a multiple of 64 sets the sticky error bit (status bit 1) and starts nothing. Writing 1 to status bit 1 clears it.
- R10: With outer set, an outer operation (op code 3) runs after all inner work, and the flag then clears. With length 0, it is the only operation.
- R11: While `suspend_req` is high, the run parks before the next data block. `busy` falls, status bit 2 is set, and the remaining length, count and pending flags stay readable. Rewriting the length resumes the run.
- R12: Writes to the mode, count and length words while `busy` is high have no effect.
- R13: Data operations use op code 1, and a key or outer operation always comes before or after all data blocks, in the stage order given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 count, 2 length, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register (combinational) |
| busy | output | 1 | A run is in progress |
| suspend_req | input | 1 | Context-switch request, sampled at block boundaries |
| core_start | output | 1 | One-cycle start of a core operation |
| core_op | output | 2 | Operation kind: 0 key, 1 data, 2 final, 3 outer |
| core_algo | output | 2 | Selected algorithm |
| core_const | output | 1 | Core should load the algorithm constants first |
| core_tail | output | 6 | Leftover byte count for a final operation |
| core_done | input | 1 | Core finished the current operation |

## Verification
The embedded assertions check properties that must hold on every cycle. They confirm that `core_start` is a single-cycle pulse and is never raised while idle. They confirm that the length is frozen between core completions, that the use-constants flag is gone after the first completion, and that a key operation only issues while key processing is pending. They also confirm that a final operation never carries 64 or more bytes, and that an error or a suspension leaves the block idle. Only the bench scenarios can show the complete operation order of each staged run and the exact counts read back afterwards. They also show the resume path after a suspension and that writes made while busy are ignored.

// File: rtl/hash_seq_pkg.sv
package hash_seq_pkg;

    localparam int BLK_BYTES = 64;
    localparam int BLK_LOG2  = $clog2(BLK_BYTES);
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_LEN   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

    // status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_SUSP = 2;
    localparam int ST_DONE = 3;

    typedef enum logic [1:0] {
        OP_KEY   = 2'd0,
        OP_DATA  = 2'd1,
        OP_FINAL = 2'd2,
        OP_OUTER = 2'd3
    } op_e;

    typedef struct packed {
        logic       outer;
        logic       key;
        logic       close;
        logic       use_const;
        logic [1:0] algo;
    } mode_t;

    typedef struct packed {
        logic valid;
        op_e  op;
    } upd_t;

    function automatic mode_t mode_from_word(input logic [31:0] w);
        mode_t m;
        m.outer     = w[7];
        m.key       = w[5];
        m.close     = w[4];
        m.use_const = w[3];
        m.algo      = w[2:1];
        return m;
    endfunction

    function automatic logic [31:0] mode_to_word(input mode_t m);
        logic [31:0] w;
        w      = '0;
        w[7]   = m.outer;
        w[5]   = m.key;
        w[4]   = m.close;
        w[3]   = m.use_const;
        w[2:1] = m.algo;
        return w;
    endfunction

endpackage

// File: rtl/hash_seq_ctx.sv
module hash_seq_ctx
    import hash_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  upd_t              upd,
    input  logic              fin_evt,
    input  logic              susp_evt,
    output mode_t             mode_q,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] rem_q,
    output logic              err_q,
    output logic              susp_q,
    output logic              done_q,
    output logic              launch
);

    localparam int LOW = BLK_LOG2;
    localparam logic [DATA_W-1:0] BLK = DATA_W'(BLK_BYTES);

    logic wr_ok;
    logic len_wr;
    logic len_bad;

    assign wr_ok   = wr_en && !busy;
    assign len_wr  = wr_ok && (wr_addr == A_LEN);
    assign len_bad = len_wr && !mode_q.close && (|wr_data[LOW-1:0]);
    assign launch  = len_wr && !len_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            count_q <= '0;
            rem_q   <= '0;
            err_q   <= 1'b0;
            susp_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (wr_ok && wr_addr == A_MODE)
                mode_q <= mode_from_word(wr_data);
            if (wr_ok && wr_addr == A_COUNT)
                count_q <= {wr_data[DATA_W-1:LOW], LOW'(0)};
            if (wr_ok && wr_addr == A_STAT && wr_data[ST_ERR])
                err_q <= 1'b0;
            if (len_bad) begin
                err_q  <= 1'b1;
                done_q <= 1'b0;
            end
            if (launch) begin
                rem_q  <= wr_data;
                done_q <= 1'b0;
                susp_q <= 1'b0;
                if (mode_q.key)
                    count_q <= BLK;
                else if (mode_q.use_const)
                    count_q <= '0;
            end
            if (upd.valid) begin
                mode_q.use_const <= 1'b0;
                case (upd.op)
                    OP_KEY:   mode_q.key <= 1'b0;
                    OP_DATA: begin
                        count_q <= count_q + BLK;
                        rem_q   <= rem_q - BLK;
                    end
                    OP_FINAL: begin
                        count_q      <= count_q + rem_q;
                        rem_q        <= '0;
                        mode_q.close <= 1'b0;
                    end
                    OP_OUTER: mode_q.outer <= 1'b0;
                    default:  ;
                endcase
            end
            if (fin_evt)
                done_q <= 1'b1;
            if (susp_evt)
                susp_q <= 1'b1;
        end
    end

    // length may only move on a core completion or a launch from idle
    p_rem_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy && !upd.valid |=> $stable(rem_q));

    p_count_hold_r12: assert property (@(posedge clk) disable iff (rst)
        busy && !upd.valid |=> $stable(count_q));

    p_const_once_r6: assert property (@(posedge clk) disable iff (rst)
        upd.valid |=> !mode_q.use_const);

    p_err_halts_r9: assert property (@(posedge clk) disable iff (rst)
        len_bad |=> (!busy && err_q));

endmodule

// File: rtl/hash_seq_fsm.sv
module hash_seq_fsm
    import hash_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  mode_t               mode,
    input  logic [DATA_W-1:0]   rem,
    input  logic                suspend_req,
    input  logic                core_done,
    output logic                busy,
    output logic                core_start,
    output op_e                 core_op,
    output logic                core_const,
    output logic [BLK_LOG2-1:0] core_tail,
    output upd_t                upd,
    output logic                fin_evt,
    output logic                susp_evt
);

    localparam logic [DATA_W-1:0] BLK = DATA_W'(BLK_BYTES);

    typedef enum logic [1:0] {S_IDLE, S_PICK, S_WAIT} state_e;

    state_e state_q;
    op_e    op_q;
    logic   start_q;
    logic   const_q;
    logic [BLK_LOG2-1:0] tail_q;

    op_e  pick_op;
    logic pick_issue;
    logic pick_susp;
    logic pick_fin;

    // stage order: key, data blocks, closing pad, outer hash
    always_comb begin
        pick_op    = OP_DATA;
        pick_issue = 1'b0;
        pick_susp  = 1'b0;
        pick_fin   = 1'b0;
        if (mode.key) begin
            pick_op    = OP_KEY;
            pick_issue = 1'b1;
        end else if (rem >= BLK) begin
            if (suspend_req)
                pick_susp = 1'b1;
            else begin
                pick_op    = OP_DATA;
                pick_issue = 1'b1;
            end
        end else if (mode.close) begin
            pick_op    = OP_FINAL;
            pick_issue = 1'b1;
        end else if (mode.outer) begin
            pick_op    = OP_OUTER;
            pick_issue = 1'b1;
        end else begin
            pick_fin = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_KEY;
            start_q <= 1'b0;
            const_q <= 1'b0;
            tail_q  <= '0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                S_IDLE: if (launch) state_q <= S_PICK;
                S_PICK: begin
                    if (pick_issue) begin
                        start_q <= 1'b1;
                        op_q    <= pick_op;
                        const_q <= mode.use_const;
                        tail_q  <= (pick_op == OP_FINAL) ? rem[BLK_LOG2-1:0] : '0;
                        state_q <= S_WAIT;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_WAIT: if (core_done) state_q <= S_PICK;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign core_start = start_q;
    assign core_op    = op_q;
    assign core_const = const_q;
    assign core_tail  = tail_q;
    assign upd.valid  = (state_q == S_WAIT) && core_done;
    assign upd.op     = op_q;
    assign fin_evt    = (state_q == S_PICK) && pick_fin;
    assign susp_evt   = (state_q == S_PICK) && pick_susp;

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !core_start);

    p_key_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (core_start && core_op == OP_KEY) |-> mode.key);

    p_final_short_r8: assert property (@(posedge clk) disable iff (rst)
        (core_start && core_op == OP_FINAL) |-> (rem < BLK));

    p_susp_parks_r11: assert property (@(posedge clk) disable iff (rst)
        susp_evt |=> !busy);

endmodule

// File: rtl/hash_seq_ctrl.sv
module hash_seq_ctrl
    import hash_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    input  logic              suspend_req,
    output logic              core_start,
    output logic [1:0]        core_op,
    output logic [1:0]        core_algo,
    output logic              core_const,
    output logic [5:0]        core_tail,
    input  logic              core_done
);

    mode_t             mode_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] rem_q;
    logic              err_q;
    logic              susp_q;
    logic              done_q;
    logic              launch;
    upd_t              upd;
    logic              fin_evt;
    logic              susp_evt;
    op_e               op_w;

    hash_seq_ctx #(.DATA_W(DATA_W)) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (addr),
        .wr_data  (wdata),
        .busy     (busy),
        .upd      (upd),
        .fin_evt  (fin_evt),
        .susp_evt (susp_evt),
        .mode_q   (mode_q),
        .count_q  (count_q),
        .rem_q    (rem_q),
        .err_q    (err_q),
        .susp_q   (susp_q),
        .done_q   (done_q),
        .launch   (launch)
    );

    hash_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .mode        (mode_q),
        .rem         (rem_q),
        .suspend_req (suspend_req),
        .core_done   (core_done),
        .busy        (busy),
        .core_start  (core_start),
        .core_op     (op_w),
        .core_const  (core_const),
        .core_tail   (core_tail),
        .upd         (upd),
        .fin_evt     (fin_evt),
        .susp_evt    (susp_evt)
    );

    assign core_op   = op_w;
    assign core_algo = mode_q.algo;

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:  rdata = DATA_W'(mode_to_word(mode_q));
            A_COUNT: rdata = count_q;
            A_LEN:   rdata = rem_q;
            A_STAT: begin
                rdata[ST_BUSY] = busy;
                rdata[ST_ERR]  = err_q;
                rdata[ST_SUSP] = susp_q;
                rdata[ST_DONE] = done_q;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: tb/sim_hash_seq_ctrl.sv
module sim_hash_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;
    logic        suspend_req = 1'b0;
    logic        core_start;
    logic [1:0]  core_op;
    logic [1:0]  core_algo;
    logic        core_const;
    logic [5:0]  core_tail;
    logic        core_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [8:0] exp_q[$];   // {op[8:7], const[6], tail[5:0]}

    always #10 clk = ~clk;  // 50 MHz

    hash_seq_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .suspend_req(suspend_req),
        .core_start(core_start), .core_op(core_op), .core_algo(core_algo),
        .core_const(core_const), .core_tail(core_tail), .core_done(core_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic expect_op(input logic [1:0] op, input logic c, input logic [5:0] tail);
        exp_q.push_back({op, c, tail});
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    // scoreboard monitor and fixed-latency core model
    always @(negedge clk) begin
        if (!rst && core_start) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R13: unexpected op actual %0d expected none", core_op);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({core_op, core_const, core_tail} !== e) begin
                    n_fail++;
                    $display("FAIL R13: op/const/tail actual 0x%0h expected 0x%0h",
                             {core_op, core_const, core_tail}, e);
                end
            end
            @(negedge clk);
            check("R5 start pulse width", {31'd0, core_start}, 32'd0);
            repeat (2) @(negedge clk);
            core_done = 1'b1;
            @(negedge clk);
            core_done = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1 mode", 2'd0, 32'h0);
        expect_reg("R1 count", 2'd1, 32'h0);
        expect_reg("R1 length", 2'd2, 32'h0);
        expect_reg("R1 status", 2'd3, 32'h0);
        check("R1 busy", {31'd0, busy}, 32'd0);

        // R2 mode field layout
        wr(2'd0, 32'hFFFF_FFFF);
        expect_reg("R2 mode readback", 2'd0, 32'hBE);
        check("R2 core_algo", {30'd0, core_algo}, 32'd3);
        wr(2'd0, 32'h0);

        // R3 count low bits dropped
        wr(2'd1, 32'h1234_567F);
        expect_reg("R3 count", 2'd1, 32'h1234_5640);

        // R5 plain two-block run
        wr(2'd0, 32'h02);
        check("R2 algo sha1", {30'd0, core_algo}, 32'd1);
        wr(2'd1, 32'h80);
        expect_op(2'd1, 1'b0, 6'd0);
        expect_op(2'd1, 1'b0, 6'd0);
        wr(2'd2, 32'd128);
        wait_idle();
        check("R5 all ops seen", exp_q.size(), 0);
        expect_reg("R5 count", 2'd1, 32'h100);
        expect_reg("R5 length", 2'd2, 32'h0);
        expect_reg("R5 status", 2'd3, 32'h8);

        // R4 zero length, no flags
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd0);
        wait_idle();
        check("R4 no ops", exp_q.size(), 0);
        expect_reg("R4 status done", 2'd3, 32'h8);
        expect_reg("R4 count kept", 2'd1, 32'h100);

        // R6 + R8 constants and close
        wr(2'd0, 32'h1E);
        wr(2'd1, 32'h400);
        expect_op(2'd1, 1'b1, 6'd0);
        expect_op(2'd2, 1'b0, 6'd36);
        wr(2'd2, 32'd100);
        wait_idle();
        check("R8 all ops seen", exp_q.size(), 0);
        expect_reg("R6 R8 count", 2'd1, 32'd100);
        expect_reg("R6 R8 flags cleared", 2'd0, 32'h06);
        expect_reg("R8 length zero", 2'd2, 32'h0);

        // R7 + R10 full HMAC run
        wr(2'd0, 32'hB4);
        expect_op(2'd0, 1'b0, 6'd0);
        expect_op(2'd1, 1'b0, 6'd0);
        expect_op(2'd2, 1'b0, 6'd0);
        expect_op(2'd3, 1'b0, 6'd0);
        wr(2'd2, 32'd64);
        wait_idle();
        check("R7 all ops seen", exp_q.size(), 0);
        expect_reg("R7 count", 2'd1, 32'd128);
        expect_reg("R7 R10 flags cleared", 2'd0, 32'h04);

        // R10 outer only
        wr(2'd0, 32'h80);
        wr(2'd1, 32'h40);
        expect_op(2'd3, 1'b0, 6'd0);
        wr(2'd2, 32'd0);
        wait_idle();
        check("R10 all ops seen", exp_q.size(), 0);
        expect_reg("R10 count", 2'd1, 32'h40);
        expect_reg("R10 mode", 2'd0, 32'h0);

        // R9 bad length without close
        wr(2'd2, 32'd70);
        repeat (8) @(negedge clk);
        check("R9 no ops", exp_q.size(), 0);
        expect_reg("R9 status err", 2'd3, 32'h2);
        expect_reg("R9 length untouched", 2'd2, 32'h0);
        wr(2'd3, 32'h2);
        expect_reg("R9 err cleared", 2'd3, 32'h0);

        // R11 suspend and resume, R12 busy writes
        wr(2'd0, 32'h10);
        wr(2'd1, 32'h0);
        expect_op(2'd1, 1'b0, 6'd0);
        wr(2'd2, 32'd256);
        @(posedge core_start);
        @(negedge clk);
        suspend_req = 1'b1;
        wait_idle();
        check("R11 one op", exp_q.size(), 0);
        expect_reg("R11 status susp", 2'd3, 32'h4);
        expect_reg("R11 length left", 2'd2, 32'd192);
        expect_reg("R11 count", 2'd1, 32'd64);
        expect_reg("R11 mode kept", 2'd0, 32'h10);
        suspend_req = 1'b0;
        expect_op(2'd1, 1'b0, 6'd0);
        expect_op(2'd1, 1'b0, 6'd0);
        expect_op(2'd1, 1'b0, 6'd0);
        expect_op(2'd2, 1'b0, 6'd0);
        wr(2'd2, 32'd192);
        wr(2'd0, 32'hFF);
        wr(2'd1, 32'h1234_0000);
        wr(2'd2, 32'd640);
        wait_idle();
        check("R11 resume ops seen", exp_q.size(), 0);
        expect_reg("R12 mode untouched", 2'd0, 32'h0);
        expect_reg("R12 count untouched", 2'd1, 32'd256);
        expect_reg("R12 length untouched", 2'd2, 32'd0);
        expect_reg("R11 status done", 2'd3, 32'h8);

        summary();
    end

endmodule